// File: doc/BRIEF.md
# Transmit Loop-Back and Fail-Safe Monitor

This block watches over a bus terminal's own transmissions. Every word the encoder sends is held until the decoder returns the copy it read back off the bus. The two are compared, and a transmitter-error output goes high on any difference. The output stays high until the next command is received. A fail-safe watchdog counts how long the transmitter stays active. If a single transmission runs past 760 microseconds, a timer output is raised. The watchdog is cleared whenever a new valid command arrives.

The block also guards the receiving side of a terminal-to-terminal transfer. Once the decoder reports the transmit command aimed at the other terminal, a 57-microsecond response window opens. The status word from the other terminal must arrive inside that window. The terminal address it carries must equal the address named in that command. A late status word or a wrong address sets message-error and raises the status-suppress output.

All durations are set in microseconds and turned into clock cycles by a cycles-per-microsecond parameter. Encoding and decoding take place outside this block. The decoder delivers the 5-bit terminal address fields already sliced out of the words.

Top module: `xmit_guard`

## Requirements
- R1: When a reflected word arrives while an encoded word is outstanding, the two 16-bit words are compared. On a difference `tx_err` is high from the clock edge that sampled the reflected word. An equal pair leaves `tx_err` low.
- R2: If the encoder sends a new word while the previous one has not yet been reflected, and no reflection comes in that cycle, this counts as a mismatch and `tx_err` goes high.
- R3: A reflected word that arrives while no encoded word is outstanding is ignored and leaves `tx_err` unchanged.
- R4: `tx_err`, `fs_on`, `msg_err` and `status_inhibit` stay high until a cycle with `cmd_valid` high. That cycle drives all four low.
- R5: `fs_on` rises on the FAILSAFE_US*CYC_PER_US-th consecutive clock edge at which `tx_active` is high (3040 edges with the defaults). A shorter run leaves it low. A cycle with `tx_active` low restarts the count.
- R6: Once high, `fs_on` stays high after `tx_active` falls. A `cmd_valid` clears it and restarts the count from zero, even while `tx_active` stays high.
- R7: A `tx_cmd_valid` pulse arms the response check and stores `tx_cmd_rta`, which is bits 15:11 of the transmit command word. A `stat_valid` with an equal `stat_rta` (bits 15:11 of the status word) inside the window leaves `msg_err` low.
- R8: An armed check that receives a `stat_valid` whose `stat_rta` differs from the stored address raises both `msg_err` and `status_inhibit`.
- R9: The response window is RESP_US*CYC_PER_US clock edges after the arming edge (228 edges with the defaults). A status word sampled on that last edge is accepted. With no status word by then, `msg_err` and `status_inhibit` rise on that edge.
- R10: A `stat_valid` while the check is not armed is ignored. This includes any status word after the first one that closed the window.
- R11: After reset, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle pulse: a valid command was received |
| enc_valid | input | 1 | One-cycle pulse: encoder sent `enc_word` |
| enc_word | input | 16 | Word sent by the encoder |
| refl_valid | input | 1 | One-cycle pulse: decoder read back `refl_word` |
| refl_word | input | 16 | Reflected word from the decoder |
| tx_active | input | 1 | Transmitter is driving the bus |
| tx_cmd_valid | input | 1 | Pulse: transmit command of a terminal-to-terminal transfer seen |
| tx_cmd_rta | input | 5 | Terminal address field of that transmit command |
| stat_valid | input | 1 | Pulse: a valid status word was received |
| stat_rta | input | 5 | Terminal address field of that status word |
| tx_err | output | 1 | Loop-back mismatch, sticky until next command |
| fs_on | output | 1 | Fail-safe timer expired |
| msg_err | output | 1 | Response address mismatch or timeout |
| status_inhibit | output | 1 | Suppress this terminal's status word |

## Verification
The bench aims at the last edge of each timed window. It checks the fail-safe at 3039 and 3040 active edges, and the response window at 227, 228 and 229 edges. An off-by-one counter would raise its output one edge early or accept a late status word. It also covers several cases. One is a word sent twice with no reflection between. Another is a reflection with nothing outstanding, which a careless design would compare against a stale word. A third is a second status word after a good one, which would wrongly raise message-error if the window never closed. It also checks that a command restarts the watchdog while the transmitter stays active. A design that only cleared the output there would time out early on the next run.

// File: rtl/xg_pkg.sv
// Shared types for the transmit guard.
// Assumes 16-bit bus words and 5-bit terminal address fields.
package xg_pkg;
    localparam int WORD_W = 16;
    localparam int RTA_W  = 5;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RTA_W-1:0]  rta_t;
endpackage

// File: rtl/xg_loopback.sv
// Loop-back comparator.
// Holds the last encoded word until its reflected copy arrives, then compares
// the two. Any mismatch, or a word sent before the previous one was reflected,
// sets a sticky error flag that only clear (a new command) removes.
// Assumes the valid inputs are single-cycle pulses.
module xg_loopback
    import xg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  enc_valid,
    input  word_t enc_word,
    input  logic  refl_valid,
    input  word_t refl_word,
    output logic  tx_err
);
    logic  pending;
    word_t sent;

    // Track the outstanding word and raise the error on mismatch or overrun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            sent    <= '0;
            tx_err  <= 1'b0;
        end else if (clear) begin
            pending <= 1'b0;
            tx_err  <= 1'b0;
        end else begin
            if (refl_valid && pending) begin
                if (refl_word != sent) tx_err <= 1'b1;
                pending <= 1'b0;
            end
            if (enc_valid) begin
                if (pending && !refl_valid) tx_err <= 1'b1;
                pending <= 1'b1;
                sent    <= enc_word;
            end
        end
    end

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err && !clear |=> tx_err);
    assert_err_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !tx_err);
    assert_err_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_err ##1 tx_err |-> $past(refl_valid) || $past(enc_valid));
    assert_no_orphan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_err && !pending && !enc_valid |=> !tx_err);
endmodule

// File: rtl/xg_failsafe.sv
// Fail-safe transmit watchdog.
// Counts consecutive cycles with the transmitter active. When the count
// reaches LIMIT, the timer output goes high and stays high until clear.
// An idle cycle restarts the count. Assumes LIMIT >= 2.
module xg_failsafe #(
    parameter int LIMIT = 3040
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tx_active,
    output logic fs_on
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Count active cycles and latch expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            fs_on <= 1'b0;
        end else if (clear) begin
            cnt   <= '0;
            fs_on <= 1'b0;
        end else if (tx_active) begin
            if (!fs_on) begin
                if (cnt == LAST) fs_on <= 1'b1;
                else             cnt   <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT));
    assert_fs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fs_on && !clear |=> fs_on);
    assert_fs_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !fs_on && cnt == '0);
    assert_fs_needs_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_on && !tx_active |=> !fs_on);
endmodule

// File: rtl/xg_rtrt_check.sv
// Terminal-to-terminal response checker.
// An arm pulse stores the expected source address and opens a window of
// LIMIT cycles. The first status word inside the window is compared with the
// stored address. A mismatch or an expired window sets a sticky failure that
// clear removes. Status words outside a window are ignored.
// Assumes LIMIT >= 2.
module xg_rtrt_check
    import xg_pkg::*;
#(
    parameter int LIMIT = 228
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic arm,
    input  rta_t arm_rta,
    input  logic stat_valid,
    input  rta_t stat_rta,
    output logic fail
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic          armed;
    logic [CW-1:0] cnt;
    rta_t          expect_rta;

    // Window timing, address compare and sticky failure
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            cnt        <= '0;
            expect_rta <= '0;
            fail       <= 1'b0;
        end else begin
            if (clear) fail <= 1'b0;
            if (arm) begin
                armed      <= 1'b1;
                cnt        <= '0;
                expect_rta <= arm_rta;
            end else if (clear) begin
                armed <= 1'b0;
            end else if (armed) begin
                if (stat_valid) begin
                    armed <= 1'b0;
                    if (stat_rta != expect_rta) fail <= 1'b1;
                end else if (cnt == LAST) begin
                    armed <= 1'b0;
                    fail  <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_win_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT));
    assert_fail_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fail && !clear |=> fail);
    assert_idle_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !armed && !arm && !clear |=> $stable(fail));
    assert_match_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !arm && !clear && !fail && stat_valid && stat_rta == expect_rta |=> !fail);
endmodule

// File: rtl/xmit_guard.sv
// Transmit loop-back and fail-safe monitor (top).
// Joins the loop-back comparator, the fail-safe watchdog and the
// terminal-to-terminal response checker. A received command clears all
// sticky outputs. Durations are given in microseconds and scaled by
// CYC_PER_US. Assumes all valid inputs are single-cycle pulses from the
// decoder side.
module xmit_guard
    import xg_pkg::*;
#(
    parameter int CYC_PER_US  = 4,
    parameter int FAILSAFE_US = 760,
    parameter int RESP_US     = 57
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        enc_valid,
    input  logic [15:0] enc_word,
    input  logic        refl_valid,
    input  logic [15:0] refl_word,
    input  logic        tx_active,
    input  logic        tx_cmd_valid,
    input  logic [4:0]  tx_cmd_rta,
    input  logic        stat_valid,
    input  logic [4:0]  stat_rta,
    output logic        tx_err,
    output logic        fs_on,
    output logic        msg_err,
    output logic        status_inhibit
);
    localparam int FS_CYC   = FAILSAFE_US * CYC_PER_US;
    localparam int RESP_CYC = RESP_US * CYC_PER_US;

    logic rtrt_fail;

    xg_loopback u_loop (
        .clk(clk), .rst_n(rst_n), .clear(cmd_valid),
        .enc_valid(enc_valid), .enc_word(enc_word),
        .refl_valid(refl_valid), .refl_word(refl_word),
        .tx_err(tx_err)
    );

    xg_failsafe #(.LIMIT(FS_CYC)) u_fs (
        .clk(clk), .rst_n(rst_n), .clear(cmd_valid),
        .tx_active(tx_active), .fs_on(fs_on)
    );

    xg_rtrt_check #(.LIMIT(RESP_CYC)) u_rtrt (
        .clk(clk), .rst_n(rst_n), .clear(cmd_valid),
        .arm(tx_cmd_valid), .arm_rta(tx_cmd_rta),
        .stat_valid(stat_valid), .stat_rta(stat_rta),
        .fail(rtrt_fail)
    );

    // A failed response both flags the error and blocks the status reply
    always_comb begin
        msg_err        = rtrt_fail;
        status_inhibit = rtrt_fail;
    end

    assert_cmd_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !tx_cmd_valid |=> !tx_err && !fs_on && !msg_err);
endmodule

// File: tb/xmit_guard_test.sv
module xmit_guard_test;
    localparam int FS  = 3040;
    localparam int RW  = 228;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 0, enc_valid = 0, refl_valid = 0, tx_active = 0;
    logic        tx_cmd_valid = 0, stat_valid = 0;
    logic [15:0] enc_word = '0, refl_word = '0;
    logic [4:0]  tx_cmd_rta = '0, stat_rta = '0;
    logic        tx_err, fs_on, msg_err, status_inhibit;
    int          checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    xmit_guard uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .enc_valid(enc_valid), .enc_word(enc_word),
        .refl_valid(refl_valid), .refl_word(refl_word),
        .tx_active(tx_active), .tx_cmd_valid(tx_cmd_valid),
        .tx_cmd_rta(tx_cmd_rta), .stat_valid(stat_valid), .stat_rta(stat_rta),
        .tx_err(tx_err), .fs_on(fs_on), .msg_err(msg_err),
        .status_inhibit(status_inhibit)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic command();
        cmd_valid = 1; step(); cmd_valid = 0;
    endtask

    task automatic send(logic [15:0] w);
        enc_valid = 1; enc_word = w; step(); enc_valid = 0;
    endtask

    task automatic reflect(logic [15:0] w);
        refl_valid = 1; refl_word = w; step(); refl_valid = 0;
    endtask

    task automatic t_reset();
        chk("R11 tx_err", tx_err, 0);
        chk("R11 fs_on", fs_on, 0);
        chk("R11 msg_err", msg_err, 0);
        chk("R11 status_inhibit", status_inhibit, 0);
    endtask

    task automatic t_loopback();
        command();
        send(16'hA5C3); reflect(16'hA5C3);
        chk("R1 equal words", tx_err, 0);
        send(16'h1234); reflect(16'h1235);
        chk("R1 mismatch", tx_err, 1);
        repeat (6) step();
        chk("R4 tx_err sticky", tx_err, 1);
        command();
        chk("R4 cmd clears tx_err", tx_err, 0);
        reflect(16'hFFFF);
        chk("R3 orphan reflection", tx_err, 0);
        send(16'h0F0F); send(16'h0F0F);
        chk("R2 overrun", tx_err, 1);
        command();
    endtask

    task automatic t_failsafe();
        command();
        tx_active = 1; repeat (FS - 1) step(); tx_active = 0; step();
        tx_active = 1; repeat (FS - 1) step();
        chk("R5 idle restarts count", fs_on, 0);
        tx_active = 0; step();
        tx_active = 1; repeat (FS - 1) step();
        chk("R5 one edge short", fs_on, 0);
        step();
        chk("R5 expiry edge", fs_on, 1);
        tx_active = 0; repeat (5) step();
        chk("R6 held after tx ends", fs_on, 1);
        tx_active = 1; cmd_valid = 1; step(); cmd_valid = 0;
        chk("R4 cmd clears fs_on", fs_on, 0);
        repeat (FS - 1) step();
        chk("R6 restart short", fs_on, 0);
        step();
        chk("R6 restart expiry", fs_on, 1);
        tx_active = 0; command();
    endtask

    task automatic arm(logic [4:0] a);
        tx_cmd_valid = 1; tx_cmd_rta = a; step(); tx_cmd_valid = 0;
    endtask

    task automatic status(logic [4:0] a);
        stat_valid = 1; stat_rta = a; step(); stat_valid = 0;
    endtask

    task automatic t_rtrt();
        command();
        status(5'd3);
        chk("R10 unarmed status", msg_err, 0);
        arm(5'd5); repeat (10) step(); status(5'd5);
        chk("R7 matching address", msg_err, 0);
        status(5'd6);
        chk("R10 second status ignored", msg_err, 0);
        arm(5'd9); status(5'd10);
        chk("R8 mismatch msg_err", msg_err, 1);
        chk("R8 mismatch inhibit", status_inhibit, 1);
        command();
        chk("R4 cmd clears msg_err", msg_err, 0);
        chk("R4 cmd clears inhibit", status_inhibit, 0);
        arm(5'd17); repeat (RW - 1) step();
        chk("R9 before timeout", msg_err, 0);
        step();
        chk("R9 timeout msg_err", msg_err, 1);
        chk("R9 timeout inhibit", status_inhibit, 1);
        command();
        arm(5'd31); repeat (RW - 1) step(); status(5'd31);
        chk("R9 last edge accepted", msg_err, 0);
        repeat (5) step();
        chk("R9 no late timeout", msg_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        t_reset();
        t_loopback();
        t_failsafe();
        t_rtrt();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule